// File: doc/BRIEF.md
# Multicycle Processor Sequencing Controller

This block is the central sequencer of a processor that spends several short clock cycles on each instruction, not one long one. It holds a 4-bit state code. From that code, the 6-bit opcode of the current instruction and an equality flag from the datapath, it drives every control point of a shared datapath. These points are the instruction register, the two operand latches, the ALU operation and operand source, the immediate extension, the result latch, memory read and write, the register-file write path and the program counter.

Five instruction classes are sequenced:

- register-register ALU operations;
- OR with a zero-extended immediate;
- word load;
- word store;
- branch when two registers are equal.

Every instruction starts with a common fetch state and a common decode state. It then follows its own path of one to three states and returns to fetch. The branch decision is taken in decode, which selects one of two different one-state paths. The outputs depend on the state alone. A transfer named by a state happens on the clock edge that leaves that state.

Top module: `mcyc_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the state code at 0000 on the next rising edge. This holds even in the middle of an instruction.
- R2: In state 0000 only `imem_rd` and `ir_en` are 1, and the next state is always 0001.
- R3: In state 0001 only `a_en` and `b_en` are 1. The next state depends on the opcode: 000000 goes to 0100, 001101 to 0110, 100011 to 1000 and 101011 to 1011. Opcode 000100 goes to 0010 when `equal` is 1 and to 0011 when it is 0.
- R4: State 0010 drives `pc_en`=1, `pc_sel_br`=1 and `ext_sign`=1. State 0011 drives `pc_en`=1 and `pc_sel_br`=0. Both states return to 0000.
- R5: State 0100 drives `alu_fn`=10 (function field), `alu_src_imm`=0 and `res_en`=1, then goes to 0101. State 0101 drives `reg_wr`, `reg_dst_rd` and `pc_en`, then returns to 0000.
- R6: State 0110 drives `alu_fn`=01 (OR), `alu_src_imm`=1, `ext_sign`=0 and `res_en`=1, then goes to 0111. State 0111 drives `reg_wr` and `pc_en` with `reg_dst_rd`=0, then returns to 0000.
- R7: State 1000 drives `alu_fn`=00 (add), `alu_src_imm`=1, `ext_sign`=1 and `res_en`=1, then goes to 1001. State 1001 drives `mem_rd` and goes to 1010. State 1010 drives `reg_wr`, `mem_to_reg` and `pc_en` with `reg_dst_rd`=0, then returns to 0000.
- R8: State 1011 drives the same address controls as state 1000 and goes to 1100. State 1100 drives `mem_wr` and `pc_en`, then returns to 0000.
- R9: An opcode outside the five listed in R3 sends decode straight back to 0000. No write enable (`reg_wr`, `mem_wr`, `pc_en`) is raised for that instruction.
- R10: `pc_en` is high for exactly one cycle per recognised instruction, in its last state. `mem_rd` and `mem_wr` are never 1 together. `equal` has no effect on any non-branch opcode. All control outputs not named for a state are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| equal | input | 1 | Operand equality flag from the datapath |
| state_o | output | 4 | Current state code |
| imem_rd | output | 1 | Instruction memory read |
| ir_en | output | 1 | Instruction register load |
| a_en | output | 1 | Operand A latch load |
| b_en | output | 1 | Operand B latch load |
| alu_fn | output | 2 | ALU operation: 00 add, 01 OR, 10 function field |
| alu_src_imm | output | 1 | ALU second operand is the extended immediate |
| ext_sign | output | 1 | Immediate is sign-extended (0: zero-extended) |
| res_en | output | 1 | ALU result latch load |
| mem_rd | output | 1 | Data memory read into the memory data latch |
| mem_wr | output | 1 | Data memory write of operand B |
| mem_to_reg | output | 1 | Register write data comes from the memory data latch |
| reg_dst_rd | output | 1 | Register write target is rd (0: rt) |
| reg_wr | output | 1 | Register file write |
| pc_en | output | 1 | Program counter update |
| pc_sel_br | output | 1 | PC takes the branch target (0: PC + 4) |

## Verification
The bench builds the block with its default widths: a 6-bit opcode and a 4-bit state code. With these widths all thirteen used state codes, both branch outcomes and an undefined opcode can be reached directly from the ports. Each path is walked state by state, and the whole control word is compared in every state. The bench also runs the branch-free paths with `equal` held at 1 and fires a reset in the middle of a load. This shows that the flag does not steer those paths and that recovery happens on the next edge.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

    localparam int OP_W  = 6;
    localparam int ST_W  = 4;
    localparam int FN_W  = 2;

    typedef enum logic [ST_W-1:0] {
        S_FETCH    = 4'b0000,
        S_DECODE   = 4'b0001,
        S_BR_TAKE  = 4'b0010,
        S_BR_SKIP  = 4'b0011,
        S_RR_EXEC  = 4'b0100,
        S_RR_WB    = 4'b0101,
        S_OI_EXEC  = 4'b0110,
        S_OI_WB    = 4'b0111,
        S_LD_ADDR  = 4'b1000,
        S_LD_MEM   = 4'b1001,
        S_LD_WB    = 4'b1010,
        S_ST_ADDR  = 4'b1011,
        S_ST_MEM   = 4'b1100
    } ctl_state_e;

    typedef enum logic [2:0] {
        K_RR, K_ORI, K_LOAD, K_STORE, K_BEQ, K_BAD
    } op_kind_e;

    typedef enum logic [FN_W-1:0] {
        ALU_ADD  = 2'b00,
        ALU_OR   = 2'b01,
        ALU_FUNC = 2'b10
    } alu_sel_e;

    localparam logic [OP_W-1:0] OPC_RR    = 6'b000000;
    localparam logic [OP_W-1:0] OPC_ORI   = 6'b001101;
    localparam logic [OP_W-1:0] OPC_LOAD  = 6'b100011;
    localparam logic [OP_W-1:0] OPC_STORE = 6'b101011;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;

    typedef struct packed {
        logic     imem_rd;
        logic     ir_en;
        logic     a_en;
        logic     b_en;
        alu_sel_e alu_fn;
        logic     alu_src_imm;
        logic     ext_sign;
        logic     res_en;
        logic     mem_rd;
        logic     mem_wr;
        logic     mem_to_reg;
        logic     reg_dst_rd;
        logic     reg_wr;
        logic     pc_en;
        logic     pc_sel_br;
    } ctl_pts_t;

    localparam ctl_pts_t CTL_IDLE = '0;

    function automatic op_kind_e classify(input logic [OP_W-1:0] op);
        op_kind_e k;
        unique case (op)
            OPC_RR:    k = K_RR;
            OPC_ORI:   k = K_ORI;
            OPC_LOAD:  k = K_LOAD;
            OPC_STORE: k = K_STORE;
            OPC_BEQ:   k = K_BEQ;
            default:   k = K_BAD;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/mcyc_opdec.sv
module mcyc_opdec
    import mcyc_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output op_kind_e        kind
);
    always_comb kind = classify(opcode);
endmodule

// File: rtl/mcyc_seq.sv
module mcyc_seq
    import mcyc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  op_kind_e   kind,
    input  logic       equal,
    output ctl_state_e state
);
    ctl_state_e nxt;

    always_comb begin
        unique case (state)
            S_FETCH:   nxt = S_DECODE;
            S_DECODE: begin
                unique case (kind)
                    K_RR:    nxt = S_RR_EXEC;
                    K_ORI:   nxt = S_OI_EXEC;
                    K_LOAD:  nxt = S_LD_ADDR;
                    K_STORE: nxt = S_ST_ADDR;
                    K_BEQ:   nxt = equal ? S_BR_TAKE : S_BR_SKIP;
                    default: nxt = S_FETCH;
                endcase
            end
            S_RR_EXEC: nxt = S_RR_WB;
            S_OI_EXEC: nxt = S_OI_WB;
            S_LD_ADDR: nxt = S_LD_MEM;
            S_LD_MEM:  nxt = S_LD_WB;
            S_ST_ADDR: nxt = S_ST_MEM;
            default:   nxt = S_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= S_FETCH;
        else     state <= nxt;
    end
endmodule

// File: rtl/mcyc_drive.sv
module mcyc_drive
    import mcyc_pkg::*;
(
    input  ctl_state_e state,
    output ctl_pts_t   ctl
);
    always_comb begin
        ctl = CTL_IDLE;
        unique case (state)
            S_FETCH: begin
                ctl.imem_rd = 1'b1;
                ctl.ir_en   = 1'b1;
            end
            S_DECODE: begin
                ctl.a_en = 1'b1;
                ctl.b_en = 1'b1;
            end
            S_BR_TAKE: begin
                ctl.ext_sign  = 1'b1;
                ctl.pc_en     = 1'b1;
                ctl.pc_sel_br = 1'b1;
            end
            S_BR_SKIP: ctl.pc_en = 1'b1;
            S_RR_EXEC: begin
                ctl.alu_fn = ALU_FUNC;
                ctl.res_en = 1'b1;
            end
            S_RR_WB: begin
                ctl.reg_wr     = 1'b1;
                ctl.reg_dst_rd = 1'b1;
                ctl.pc_en      = 1'b1;
            end
            S_OI_EXEC: begin
                ctl.alu_fn      = ALU_OR;
                ctl.alu_src_imm = 1'b1;
                ctl.res_en      = 1'b1;
            end
            S_OI_WB: begin
                ctl.reg_wr = 1'b1;
                ctl.pc_en  = 1'b1;
            end
            S_LD_ADDR, S_ST_ADDR: begin
                ctl.alu_fn      = ALU_ADD;
                ctl.alu_src_imm = 1'b1;
                ctl.ext_sign    = 1'b1;
                ctl.res_en      = 1'b1;
            end
            S_LD_MEM: ctl.mem_rd = 1'b1;
            S_LD_WB: begin
                ctl.reg_wr     = 1'b1;
                ctl.mem_to_reg = 1'b1;
                ctl.pc_en      = 1'b1;
            end
            S_ST_MEM: begin
                ctl.mem_wr = 1'b1;
                ctl.pc_en  = 1'b1;
            end
            default: ctl = CTL_IDLE;
        endcase
    end
endmodule

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
    import mcyc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] opcode,
    input  logic            equal,
    output logic [ST_W-1:0] state_o,
    output logic            imem_rd,
    output logic            ir_en,
    output logic            a_en,
    output logic            b_en,
    output logic [FN_W-1:0] alu_fn,
    output logic            alu_src_imm,
    output logic            ext_sign,
    output logic            res_en,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            mem_to_reg,
    output logic            reg_dst_rd,
    output logic            reg_wr,
    output logic            pc_en,
    output logic            pc_sel_br
);
    op_kind_e   kind;
    ctl_state_e state;
    ctl_pts_t   ctl;

    mcyc_opdec i_opdec (.opcode(opcode), .kind(kind));

    mcyc_seq i_seq (
        .clk(clk), .rst(rst), .kind(kind), .equal(equal), .state(state)
    );

    mcyc_drive i_drive (.state(state), .ctl(ctl));

    assign state_o     = state;
    assign imem_rd     = ctl.imem_rd;
    assign ir_en       = ctl.ir_en;
    assign a_en        = ctl.a_en;
    assign b_en        = ctl.b_en;
    assign alu_fn      = ctl.alu_fn;
    assign alu_src_imm = ctl.alu_src_imm;
    assign ext_sign    = ctl.ext_sign;
    assign res_en      = ctl.res_en;
    assign mem_rd      = ctl.mem_rd;
    assign mem_wr      = ctl.mem_wr;
    assign mem_to_reg  = ctl.mem_to_reg;
    assign reg_dst_rd  = ctl.reg_dst_rd;
    assign reg_wr      = ctl.reg_wr;
    assign pc_en       = ctl.pc_en;
    assign pc_sel_br   = ctl.pc_sel_br;
endmodule

// File: rtl/mcyc_ctrl_chk.sv
module mcyc_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic [5:0] opcode,
    input logic       equal,
    input logic [3:0] state_o,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       pc_en,
    input logic       reg_wr
);
    logic op_known;
    always_comb op_known = (opcode == 6'b000000) || (opcode == 6'b001101) ||
                           (opcode == 6'b100011) || (opcode == 6'b101011) ||
                           (opcode == 6'b000100);

    a_r1_reset_to_fetch: assert property (@(posedge clk)
        rst |=> state_o == 4'b0000);

    a_r2_fetch_to_decode: assert property (@(posedge clk) disable iff (rst)
        state_o == 4'b0000 |=> state_o == 4'b0001);

    a_r3_load_dispatch: assert property (@(posedge clk) disable iff (rst)
        (state_o == 4'b0001 && opcode == 6'b100011) |=> state_o == 4'b1000);

    a_r4_branch_taken: assert property (@(posedge clk) disable iff (rst)
        (state_o == 4'b0001 && opcode == 6'b000100 && equal) |=> state_o == 4'b0010);

    a_r4_branch_skip: assert property (@(posedge clk) disable iff (rst)
        (state_o == 4'b0001 && opcode == 6'b000100 && !equal) |=> state_o == 4'b0011);

    a_r9_bad_opcode: assert property (@(posedge clk) disable iff (rst)
        (state_o == 4'b0001 && !op_known) |=> (state_o == 4'b0000 && !reg_wr && !mem_wr && !pc_en));

    a_r10_mem_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    a_r10_pc_last_state: assert property (@(posedge clk) disable iff (rst)
        pc_en |=> state_o == 4'b0000);
endmodule

bind mcyc_ctrl mcyc_ctrl_chk i_chk (
    .clk(clk), .rst(rst), .opcode(opcode), .equal(equal), .state_o(state_o),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .pc_en(pc_en), .reg_wr(reg_wr)
);

// File: tb/test_mcyc_ctrl.sv
`timescale 1ns/1ps
module test_mcyc_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = '0;
    logic       equal = 1'b0;
    logic [3:0] state_o;
    logic       imem_rd, ir_en, a_en, b_en, alu_src_imm, ext_sign, res_en;
    logic       mem_rd, mem_wr, mem_to_reg, reg_dst_rd, reg_wr, pc_en, pc_sel_br;
    logic [1:0] alu_fn;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mcyc_ctrl i_mcyc_ctrl (
        .clk(clk), .rst(rst), .opcode(opcode), .equal(equal), .state_o(state_o),
        .imem_rd(imem_rd), .ir_en(ir_en), .a_en(a_en), .b_en(b_en),
        .alu_fn(alu_fn), .alu_src_imm(alu_src_imm), .ext_sign(ext_sign),
        .res_en(res_en), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_to_reg(mem_to_reg), .reg_dst_rd(reg_dst_rd), .reg_wr(reg_wr),
        .pc_en(pc_en), .pc_sel_br(pc_sel_br)
    );

    // order: imem_rd ir_en a_en b_en alu_fn[1:0] src_imm ext_sign res_en
    //        mem_rd mem_wr mem_to_reg dst_rd reg_wr pc_en pc_sel_br
    function automatic logic [15:0] ctl_now();
        return {imem_rd, ir_en, a_en, b_en, alu_fn, alu_src_imm, ext_sign, res_en,
                mem_rd, mem_wr, mem_to_reg, reg_dst_rd, reg_wr, pc_en, pc_sel_br};
    endfunction

    function automatic logic [15:0] ctl_exp(input logic [3:0] s);
        case (s)
            4'b0000: return 16'b1100_00_000_0000000;          // R2
            4'b0001: return 16'b0011_00_000_0000000;          // R3
            4'b0010: return 16'b0000_00_010_0000011;          // R4
            4'b0011: return 16'b0000_00_000_0000010;          // R4
            4'b0100: return 16'b0000_10_001_0000000;          // R5
            4'b0101: return 16'b0000_00_000_0001110;          // R5
            4'b0110: return 16'b0000_01_101_0000000;          // R6
            4'b0111: return 16'b0000_00_000_0000110;          // R6
            4'b1000: return 16'b0000_00_111_0000000;          // R7
            4'b1001: return 16'b0000_00_000_1000000;          // R7
            4'b1010: return 16'b0000_00_000_0010110;          // R7
            4'b1011: return 16'b0000_00_111_0000000;          // R8
            4'b1100: return 16'b0000_00_000_0100010;          // R8
            default: return 16'b0;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // walks n states starting at the fetch state now on the outputs
    task automatic run_path(input string req, input logic [5:0] op, input logic eq,
                            input int n, input logic [23:0] path, input int exp_pc);
        int pcs = 0;
        opcode = op;
        equal  = eq;
        for (int i = 0; i < n; i++) begin
            logic [3:0] s;
            s = path[i*4 +: 4];
            chk(req, "state", int'(state_o), int'(s));
            chk(req, "controls", int'(ctl_now()), int'(ctl_exp(s)));
            if (pc_en) pcs++;
            @(negedge clk);
        end
        chk(req, "back at fetch", int'(state_o), 0);
        chk("R10", "pc_en cycles", pcs, exp_pc);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "reset state", int'(state_o), 0);
        chk("R1", "reset controls", int'(ctl_now()), int'(ctl_exp(4'b0000)));
        rst = 1'b0;
    endtask

    task automatic t_rr(input logic eq);
        run_path("R5", 6'b000000, eq, 4, {8'h0, 4'b0101, 4'b0100, 4'b0001, 4'b0000}, 1);
    endtask

    task automatic t_ori(input logic eq);
        run_path("R6", 6'b001101, eq, 4, {8'h0, 4'b0111, 4'b0110, 4'b0001, 4'b0000}, 1);
    endtask

    task automatic t_load(input logic eq);
        run_path("R7", 6'b100011, eq, 5, {4'h0, 4'b1010, 4'b1001, 4'b1000, 4'b0001, 4'b0000}, 1);
    endtask

    task automatic t_store(input logic eq);
        run_path("R8", 6'b101011, eq, 4, {8'h0, 4'b1100, 4'b1011, 4'b0001, 4'b0000}, 1);
    endtask

    task automatic t_beq(input logic eq);
        if (eq) run_path("R4", 6'b000100, 1'b1, 3, {12'h0, 4'b0010, 4'b0001, 4'b0000}, 1);
        else    run_path("R4", 6'b000100, 1'b0, 3, {12'h0, 4'b0011, 4'b0001, 4'b0000}, 1);
    endtask

    task automatic t_bad(input logic [5:0] op);
        run_path("R9", op, 1'b1, 2, {16'h0, 4'b0001, 4'b0000}, 0);
    endtask

    task automatic t_reset_mid();
        opcode = 6'b100011;
        @(negedge clk);                       // decode
        @(negedge clk);                       // 1000
        chk("R1", "pre-reset state", int'(state_o), 8);
        rst = 1'b1;
        @(negedge clk);
        chk("R1", "mid-instruction reset", int'(state_o), 0);
        rst = 1'b0;
    endtask

    initial begin
        for (int c = 0; c < 5000; c++) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_rr(1'b0);
        t_rr(1'b1);          // R10: equal ignored
        t_ori(1'b0);
        t_ori(1'b1);
        t_load(1'b0);
        t_load(1'b1);
        t_store(1'b1);
        t_beq(1'b1);
        t_beq(1'b0);
        t_bad(6'b111111);
        t_bad(6'b000010);
        t_reset_mid();
        t_store(1'b0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule